// File: doc/BRIEF.md
# Effective Clock Frequency Monitor

This block estimates how fast a core really ran during a measurement window. It keeps two event counters side by side. One counts a pulse that marks each core clock cycle actually executed. The other counts a tick that arrives at a fixed rate and does not depend on the core clock. A window timer running on the monitor clock closes the window after a programmed number of cycles. At that point both counts are captured together and both running counters start again from zero.

The captured pair feeds a sequential divider. The divider forms the programmed nominal frequency (in MHz) times the core count, divided by the reference count. The result is the effective frequency in MHz, truncated to an integer. A nominal setting of 2400 MHz is the usual one. Two flags compare the captured counts directly: one shows the core ran faster than nominal, the other that it ran slower, for example while it sat idle. A window of about 20 ms is typical in use. The window length is an input, so shorter windows serve tests.

Top module: `eff_clk_monitor`

## Requirements
- R1: While reset is held, every output reads zero: counts, sample pulse, both flags, frequency, done pulse and error flag.
- R2: With a window setting of L (L at least 1), `sample_valid` pulses for one cycle once every L monitor clock cycles.
- R3: Each captured count equals the number of cycles in which its tick input was high during the window just closed, including the window's last cycle. Counting for the next window starts from zero.
- R4: A running count that reaches all ones holds there and does not wrap, until the window closes.
- R5: When the reference count is non-zero, `freq_mhz` equals floor(core_count × nom_mhz / ref_count), using the `nom_mhz` value present in the cycle of `sample_valid`.
- R6: `above_nom` is 1 exactly when the captured core count exceeds the captured reference count, and `below_nom` is 1 exactly when it is smaller. When the counts are equal, both are 0. The flags change only together with `sample_valid`.
- R7: When the reference count is non-zero, `freq_done` pulses CNT_W+NOM_W+1 cycles after `sample_valid`, with `freq_err` = 0.
- R8: When the reference count is zero, `freq_done` pulses one cycle after `sample_valid`, with `freq_mhz` = 0 and `freq_err` = 1.
- R9: `freq_mhz` and `freq_err` change only in a cycle in which `freq_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_tick | input | 1 | High for each executed core cycle |
| ref_tick | input | 1 | Fixed-rate reference tick |
| win_len | input | WIN_W | Window length in monitor clock cycles (0 acts as 1) |
| nom_mhz | input | NOM_W | Nominal frequency in MHz |
| act_count | output | CNT_W | Captured core-cycle count |
| ref_count | output | CNT_W | Captured reference count |
| sample_valid | output | 1 | One-cycle pulse when new counts are captured |
| above_nom | output | 1 | Captured core count exceeds reference count |
| below_nom | output | 1 | Captured core count is below reference count |
| freq_mhz | output | CNT_W+NOM_W | Effective frequency in MHz, truncated |
| freq_done | output | 1 | One-cycle pulse when a new result is ready |
| freq_err | output | 1 | Last result came from a zero reference count |

## Verification
The bench builds the block with CNT_W=10, NOM_W=16 and WIN_W=12. The 10-bit counters let a window of about a thousand cycles drive a count into saturation, which a 32-bit counter would never reach in a run. The divider latency also shrinks to 27 cycles, so windows of 40 to 64 cycles can be chained back to back. At these sizes the test covers equal rates, faster and slower cores, a silent reference, a silent core, and saturation, as well as randomized tick densities and nominal values.

// File: rtl/efm_pkg.sv
package efm_pkg;

  typedef struct packed {
    logic above;
    logic below;
  } rate_cmp_t;

  typedef enum logic [0:0] {
    DV_IDLE = 1'b0,
    DV_RUN  = 1'b1
  } div_state_e;

  // Direct comparison of two captured counts (zero-extended by caller).
  function automatic rate_cmp_t rate_cmp(input logic [63:0] act,
                                         input logic [63:0] refc);
    rate_cmp_t r;
    r.above = (act > refc);
    r.below = (act < refc);
    return r;
  endfunction

endpackage

// File: rtl/efm_window_timer.sv
module efm_window_timer #(
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);

  logic [WIN_W-1:0] cnt;
  logic [WIN_W-1:0] last_idx;

  assign last_idx = (win_len == '0) ? '0 : win_len - 1'b1;
  assign win_end  = (cnt >= last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (win_end) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R2: the window index restarts after each window end
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt == '0));

endmodule

// File: rtl/efm_tick_counter.sv
module efm_tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             close_win,
  output logic [CNT_W-1:0] captured
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] run_next;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic inc);
    return (v == CNT_MAX) ? v : v + CNT_W'(inc);
  endfunction

  assign run_next = sat_inc(run, tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= '0;
      captured <= '0;
    end else if (close_win) begin
      captured <= run_next;
      run      <= '0;
    end else begin
      run <= run_next;
    end
  end

  // R3: running count restarts from zero after a window closes
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    close_win |=> (run == '0));

  // R4: a full counter stays full inside a window
  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run == CNT_MAX && !close_win) |=> (run == CNT_MAX));

  // R3: captured value only moves at a window close
  p_cap_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !close_win |=> $stable(captured));

endmodule

// File: rtl/efm_ratio_div.sv
module efm_ratio_div #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             done,
  output logic             err
);

  import efm_pkg::*;

  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int CHK_W  = NUM_W + DEN_W;

  div_state_e        state;
  logic [STEP_W-1:0] steps_left;
  logic [DEN_W-1:0]  rem;
  logic [NUM_W-1:0]  q;
  logic [DEN_W-1:0]  den_q;
  logic [NUM_W-1:0]  num_q;
  logic [DEN_W-1:0]  rem_n;
  logic [NUM_W-1:0]  q_n;
  logic              last_step;

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  function automatic logic [DEN_W+NUM_W-1:0] div_step(
      input logic [DEN_W-1:0] r, input logic [NUM_W-1:0] qq,
      input logic [DEN_W-1:0] d);
    logic [DEN_W:0] t;
    logic           bit_in;
    t      = {r, qq[NUM_W-1]};
    bit_in = (t >= {1'b0, d});
    if (bit_in) t = t - {1'b0, d};
    return {t[DEN_W-1:0], qq[NUM_W-2:0], bit_in};
  endfunction

  assign {rem_n, q_n} = div_step(rem, q, den_q);
  assign last_step    = (state == DV_RUN) && (steps_left == STEP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= DV_IDLE;
      steps_left <= '0;
      rem        <= '0;
      q          <= '0;
      den_q      <= '0;
      num_q      <= '0;
      quot       <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        den_q <= den;
        num_q <= num;
        rem   <= '0;
        q     <= num;
        if (den == '0) begin
          state <= DV_IDLE;
          quot  <= '0;
          err   <= 1'b1;
          done  <= 1'b1;
        end else begin
          state      <= DV_RUN;
          steps_left <= STEP_W'(NUM_W);
        end
      end else if (state == DV_RUN) begin
        rem        <= rem_n;
        q          <= q_n;
        steps_left <= steps_left - 1'b1;
        if (last_step) begin
          state <= DV_IDLE;
          quot  <= q_n;
          err   <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  // Bounds of a truncated quotient, brought out for the checks below.
  logic [CHK_W-1:0] chk_lo;
  logic [CHK_W-1:0] chk_hi;
  assign chk_lo = CHK_W'(quot) * CHK_W'(den_q);
  assign chk_hi = chk_lo + CHK_W'(den_q);

  // R5: result is the floor of num/den
  p_quot_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (chk_lo <= CHK_W'(num_q) && CHK_W'(num_q) < chk_hi));

  // R8: zero divisor gives a zero result
  p_zero_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (quot == '0 && den_q == '0));

  // R9: result holds between completions
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quot) && $stable(err)));

endmodule

// File: rtl/eff_clk_monitor.sv
module eff_clk_monitor #(
  parameter int CNT_W = 32,
  parameter int NOM_W = 16,
  parameter int WIN_W = 24,
  localparam int PROD_W = CNT_W + NOM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_tick,
  input  logic              ref_tick,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [NOM_W-1:0]  nom_mhz,
  output logic [CNT_W-1:0]  act_count,
  output logic [CNT_W-1:0]  ref_count,
  output logic              sample_valid,
  output logic              above_nom,
  output logic              below_nom,
  output logic [PROD_W-1:0] freq_mhz,
  output logic              freq_done,
  output logic              freq_err
);

  import efm_pkg::*;

  logic             win_end;
  logic [PROD_W-1:0] scaled_num;
  rate_cmp_t        cmp;

  efm_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_len (win_len),
    .win_end (win_end)
  );

  // One counter per stream; index 0 counts core cycles, 1 reference ticks.
  logic [1:0]            tick_in;
  logic [1:0][CNT_W-1:0] cap;
  assign tick_in = {ref_tick, core_tick};

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    efm_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_in[i]),
      .close_win (win_end),
      .captured  (cap[i])
    );
  end

  assign act_count = cap[0];
  assign ref_count = cap[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sample_valid <= 1'b0;
    else        sample_valid <= win_end;
  end

  assign cmp       = rate_cmp(64'(act_count), 64'(ref_count));
  assign above_nom = cmp.above;
  assign below_nom = cmp.below;

  assign scaled_num = PROD_W'(act_count) * PROD_W'(nom_mhz);

  efm_ratio_div #(.NUM_W(PROD_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sample_valid),
    .num   (scaled_num),
    .den   (ref_count),
    .quot  (freq_mhz),
    .done  (freq_done),
    .err   (freq_err)
  );

  // R6: the two flags are never high together
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({above_nom, below_nom}));

  // R6: flags only move with a new sample
  p_flags_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(above_nom) && $stable(below_nom)));

  // R2: a capture pulse lasts only one cycle unless the window is one cycle
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && win_len > WIN_W'(1)) |=> !sample_valid);

endmodule

// File: tb/tb_eff_clk_monitor.sv
module tb_eff_clk_monitor;

  localparam int CNT_W  = 10;
  localparam int NOM_W  = 16;
  localparam int WIN_W  = 12;
  localparam int PROD_W = CNT_W + NOM_W;
  localparam longint CMAX = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              core_tick = 1'b0;
  logic              ref_tick = 1'b0;
  logic [WIN_W-1:0]  win_len = '0;
  logic [NOM_W-1:0]  nom_mhz = '0;
  logic [CNT_W-1:0]  act_count;
  logic [CNT_W-1:0]  ref_count;
  logic              sample_valid;
  logic              above_nom;
  logic              below_nom;
  logic [PROD_W-1:0] freq_mhz;
  logic              freq_done;
  logic              freq_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  eff_clk_monitor #(.CNT_W(CNT_W), .NOM_W(NOM_W), .WIN_W(WIN_W)) dut (
    .clk, .rst_n, .core_tick, .ref_tick, .win_len, .nom_mhz,
    .act_count, .ref_count, .sample_valid, .above_nom, .below_nom,
    .freq_mhz, .freq_done, .freq_err
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic longint sat(input longint v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic longint exp_freq(input longint a, input longint n, input longint r);
    return (r == 0) ? 0 : (a * n) / r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_seg(input int len, input int nom, input int pa,
                         input int pr, input int nwin);
    longint acc_a = 0, acc_r = 0, last = 0, cyc = 0;
    longint eq = 0, elat = 0, prev_f = 0;
    bit     eerr = 0, pend = 0, prev_e = 0;
    int     seen = 0, waitc = 0, guard = 0;
    @(negedge clk);
    rst_n = 1'b0; core_tick = 1'b0; ref_tick = 1'b0;
    win_len = WIN_W'(len); nom_mhz = NOM_W'(nom);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(act_count == 0 && ref_count == 0, "R1", "counts in reset", act_count, 0);
    chk(!sample_valid && !freq_done && !freq_err, "R1", "pulses in reset",
        {sample_valid, freq_done, freq_err}, 0);
    chk(!above_nom && !below_nom && freq_mhz == 0, "R1", "flags/freq in reset",
        freq_mhz, 0);
    rst_n = 1'b1;
    while ((seen < nwin || pend) && guard < 20000) begin
      guard++;
      if (pend) begin
        waitc++;
        if (freq_done) begin
          chk(waitc == elat, eerr ? "R8" : "R7", "done latency", waitc, elat);
          chk(freq_mhz == eq, "R5", "frequency", freq_mhz, eq);
          chk(freq_err == eerr, eerr ? "R8" : "R7", "error flag", freq_err, eerr);
          pend = 0;
        end else begin
          chk(freq_mhz == prev_f && freq_err == prev_e, "R9", "hold before done",
              freq_mhz, prev_f);
        end
      end
      if (sample_valid && seen < nwin) begin
        chk(act_count == sat(acc_a), (acc_a > CMAX) ? "R4" : "R3", "core count",
            act_count, sat(acc_a));
        chk(ref_count == sat(acc_r), (acc_r > CMAX) ? "R4" : "R3", "ref count",
            ref_count, sat(acc_r));
        chk(above_nom == (sat(acc_a) > sat(acc_r)), "R6", "above flag",
            above_nom, sat(acc_a) > sat(acc_r));
        chk(below_nom == (sat(acc_a) < sat(acc_r)), "R6", "below flag",
            below_nom, sat(acc_a) < sat(acc_r));
        if (seen > 0) chk(cyc - last == len, "R2", "window period", cyc - last, len);
        last   = cyc;
        eq     = exp_freq(sat(acc_a), nom, sat(acc_r));
        eerr   = (sat(acc_r) == 0);
        elat   = eerr ? 1 : PROD_W + 1;
        prev_f = freq_mhz;
        prev_e = freq_err;
        pend   = 1; waitc = 0; seen++;
        acc_a  = 0; acc_r = 0;
      end
      core_tick = ($urandom_range(99) < pa);
      ref_tick  = ($urandom_range(99) < pr);
      acc_a += core_tick;
      acc_r += ref_tick;
      @(negedge clk);
      cyc++;
    end
    chk(guard < 20000, "R2", "segment completed", guard, nwin);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    run_seg(40,   2400, 100, 100, 3);  // R5 R6: equal rates give nominal
    run_seg(64,   2400,  70,  30, 6);  // R6: above nominal
    run_seg(50,   3000,  20,  60, 5);  // R6: below nominal
    run_seg(45,   2400,  50,   0, 3);  // R8: silent reference
    run_seg(45,   2400,   0,  50, 3);  // R5: idle core gives zero
    run_seg(1100, 2400, 100,  40, 2);  // R4: core count saturates
    for (int k = 0; k < 5; k++)
      run_seg(40 + $urandom_range(60), 1000 + $urandom_range(4000),
              $urandom_range(100), 1 + $urandom_range(99), 4);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule